// File: doc/BRIEF.md
# DDR SDRAM Command Timing Monitor

This block is a passive observer for a DDR SDRAM command bus. On every rising clock edge it looks at the chip-select, row strobe, column strobe, write enable, bank and address lines and decodes one command. For each of the four banks it tracks whether a row is open. Down-counters enforce the minimum spacing between related commands. When a command breaks a spacing or ordering rule, the monitor reports it for one cycle with a 4-bit code that names the rule and the bank involved. It never drives the bus.

Every limit is a parameter counted in clock cycles. The defaults match a 5 ns clock. The block is meant to sit beside a memory controller, either in a test build or in a debug build. It catches command streams that a real device would reject or silently corrupt. A command that breaks a rule still updates the tracked state as if it were legal, so one mistake does not cascade into false reports. The one exception is a read or write to an idle bank, which changes nothing.

Top module: `ddr_cmd_timing_mon`

## Requirements
- R1: A command is decoded only when `cke` was high at the previous rising edge (`cke` counts as low after reset) and `cs_n` is low. With `cs_n` low, the encoding of {`ras_n`,`cas_n`,`we_n`} is: 011 ACTIVATE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH, 000 LOAD MODE (any bank value), 110 BURST STOP. The value 111 is a no-operation. Deselect, no-operation and unsampled cycles never raise a violation.
- R2: A violation caused by the command at edge N shows up after edge N as `viol_valid`=1, with `viol_code` and `viol_bank` valid, for exactly one cycle. When no violation is reported, `viol_code` is 0 and `viol_bank` is 0. Both are also 0 out of reset.
- R3: A READ or WRITE to a bank with no open row reports code 1 with that bank, and it leaves the tracked state unchanged.
- R4: An ACTIVATE to a bank that already has an open row reports code 2.
- R5: A REFRESH while any bank is open reports code 3, with `viol_bank` set to the lowest-numbered open bank.
- R6: A PRECHARGE with `addr[10]`=1 closes every bank. With `addr[10]`=0 it closes only the bank named by `ba`.
- R7: A READ or WRITE issued fewer than T_RCD edges after the ACTIVATE of its bank reports code 4.
- R8: A PRECHARGE that closes an open bank fewer than T_RAS edges after that bank's ACTIVATE reports code 5. A PRECHARGE that closes it fewer than T_WR edges after a WRITE to it reports code 6.
- R9: An ACTIVATE fewer than T_RC edges after the previous ACTIVATE of the same bank reports code 7. An ACTIVATE fewer than T_RP edges after the PRECHARGE that closed that bank reports code 8.
- R10: An ACTIVATE to any bank fewer than T_RRD edges after an ACTIVATE to any bank reports code 9.
- R11: An ACTIVATE or REFRESH fewer than T_MRD edges after a LOAD MODE reports code 10. A LOAD MODE or PRECHARGE fewer than T_RFC edges after a REFRESH reports code 11.
- R12: When several rules break at once, the smallest code is reported. For a per-bank rule (codes 1, 2, 4 to 8), the bank is the lowest-numbered bank breaking that rule. For codes 9 to 11, the bank is the command's `ba`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bus is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable of the observed bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Address bus; bit 10 selects all-bank precharge |
| viol_valid | output | 1 | One-cycle violation pulse |
| viol_code | output | 4 | Rule broken (0 when none) |
| viol_bank | output | BA_W | Bank tied to the violation |

## Verification
Several rules can break on the same command. The clearest case is an ACTIVATE that comes back too soon after an early PRECHARGE, which can break both the activate-to-activate spacing of the bank and its precharge recovery. The bench provokes this by closing a bank exactly T_RAS edges after opening it and reopening it after a short gap, and it expects code 7 rather than 8. It also reopens an already-open bank on the very next cycle, which breaks rules 2, 7 and 9 together, and it issues an all-bank precharge that catches two young banks at once. In each case the bench judges the reported code and bank against the priority order.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

  typedef enum logic [2:0] {
    C_NONE, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_LMR, C_BST
  } cmd_e;

  // Lower value = higher reporting priority; V_NONE means no fault.
  typedef enum logic [3:0] {
    V_NONE     = 4'd0,
    V_CLOSED   = 4'd1,
    V_REOPEN   = 4'd2,
    V_REF_OPEN = 4'd3,
    V_RCD      = 4'd4,
    V_RAS      = 4'd5,
    V_WREC     = 4'd6,
    V_RC       = 4'd7,
    V_RP       = 4'd8,
    V_RRD      = 4'd9,
    V_MRD      = 4'd10,
    V_RFC      = 4'd11
  } viol_e;

  function automatic cmd_e decode_cmd(logic cs_n, logic ras_n, logic cas_n, logic we_n);
    if (cs_n) return C_NONE;
    case ({ras_n, cas_n, we_n})
      3'b011:  return C_ACT;
      3'b101:  return C_RD;
      3'b100:  return C_WR;
      3'b010:  return C_PRE;
      3'b001:  return C_REF;
      3'b000:  return C_LMR;
      3'b110:  return C_BST;
      default: return C_NONE;
    endcase
  endfunction

  // Bits needed to hold lim-1.
  function automatic int unsigned cnt_bits(int unsigned lim);
    return (lim <= 2) ? 1 : $clog2(lim);
  endfunction

  // Next value of a spacing timer: reload on its start command, else count to zero.
  function automatic int unsigned tick(logic load, int unsigned lim, int unsigned cur);
    if (load) return lim - 1;
    return (cur == 0) ? 0 : cur - 1;
  endfunction

  function automatic viol_e pick_first(viol_e a, viol_e b);
    if (a == V_NONE) return b;
    if (b == V_NONE) return a;
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_mon_decode.sv
module ddr_mon_decode
  import ddr_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  logic cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke;
  end

  always_comb begin
    cmd = cke_q ? decode_cmd(cs_n, ras_n, cas_n, we_n) : C_NONE;
  end
endmodule

// File: rtl/ddr_mon_bank.sv
module ddr_mon_bank
  import ddr_mon_pkg::*;
#(
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_RAS = 8,
  parameter int unsigned T_RC  = 11,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_WR  = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  cmd_e  cmd,
  input  logic  hit,
  input  logic  pre_all,
  output logic  open_o,
  output viol_e code_o
);
  localparam int unsigned RCD_W = cnt_bits(T_RCD);
  localparam int unsigned RAS_W = cnt_bits(T_RAS);
  localparam int unsigned RC_W  = cnt_bits(T_RC);
  localparam int unsigned RP_W  = cnt_bits(T_RP);
  localparam int unsigned WR_W  = cnt_bits(T_WR);

  logic             open_q;
  logic [RCD_W-1:0] rcd_q;
  logic [RAS_W-1:0] ras_q;
  logic [RC_W-1:0]  rc_q;
  logic [RP_W-1:0]  rp_q;
  logic [WR_W-1:0]  wr_q;

  logic ev_act, ev_rw, ev_wr, ev_close;
  assign ev_act   = (cmd == C_ACT) && hit;
  assign ev_rw    = ((cmd == C_RD) || (cmd == C_WR)) && hit;
  assign ev_wr    = (cmd == C_WR) && hit && open_q;
  assign ev_close = (cmd == C_PRE) && (hit || pre_all) && open_q;

  always_comb begin
    code_o = V_NONE;
    if (ev_rw) begin
      if (!open_q)          code_o = V_CLOSED;
      else if (rcd_q != 0)  code_o = V_RCD;
    end else if (ev_act) begin
      if (open_q)           code_o = V_REOPEN;
      else if (rc_q != 0)   code_o = V_RC;
      else if (rp_q != 0)   code_o = V_RP;
    end else if (ev_close) begin
      if (ras_q != 0)       code_o = V_RAS;
      else if (wr_q != 0)   code_o = V_WREC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rcd_q  <= '0;
      ras_q  <= '0;
      rc_q   <= '0;
      rp_q   <= '0;
      wr_q   <= '0;
    end else begin
      if (ev_act)        open_q <= 1'b1;
      else if (ev_close) open_q <= 1'b0;
      rcd_q <= RCD_W'(tick(ev_act,   T_RCD, int'(rcd_q)));
      ras_q <= RAS_W'(tick(ev_act,   T_RAS, int'(ras_q)));
      rc_q  <= RC_W'(tick(ev_act,    T_RC,  int'(rc_q)));
      rp_q  <= RP_W'(tick(ev_close,  T_RP,  int'(rp_q)));
      wr_q  <= WR_W'(tick(ev_wr,     T_WR,  int'(wr_q)));
    end
  end

  assign open_o = open_q;
endmodule

// File: rtl/ddr_mon_shared.sv
module ddr_mon_shared
  import ddr_mon_pkg::*;
#(
  parameter int unsigned BA_W  = 2,
  parameter int unsigned T_RRD = 2,
  parameter int unsigned T_MRD = 2,
  parameter int unsigned T_RFC = 14,
  localparam int unsigned NBANK = 1 << BA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [BA_W-1:0]  ba,
  input  logic [NBANK-1:0] bank_open,
  output viol_e            code_o,
  output logic [BA_W-1:0]  bank_o
);
  localparam int unsigned RRD_W = cnt_bits(T_RRD);
  localparam int unsigned MRD_W = cnt_bits(T_MRD);
  localparam int unsigned RFC_W = cnt_bits(T_RFC);

  logic [RRD_W-1:0] rrd_q;
  logic [MRD_W-1:0] mrd_q;
  logic [RFC_W-1:0] rfc_q;
  logic [BA_W-1:0]  low_open;

  always_comb begin
    low_open = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (bank_open[i]) low_open = BA_W'(i);
    end
  end

  always_comb begin
    code_o = V_NONE;
    case (cmd)
      C_ACT: begin
        if (rrd_q != 0)      code_o = V_RRD;
        else if (mrd_q != 0) code_o = V_MRD;
      end
      C_REF: begin
        if (|bank_open)      code_o = V_REF_OPEN;
        else if (mrd_q != 0) code_o = V_MRD;
      end
      C_LMR, C_PRE: begin
        if (rfc_q != 0)      code_o = V_RFC;
      end
      default: code_o = V_NONE;
    endcase
    bank_o = (code_o == V_REF_OPEN) ? low_open : ba;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_q <= '0;
      mrd_q <= '0;
      rfc_q <= '0;
    end else begin
      rrd_q <= RRD_W'(tick(cmd == C_ACT, T_RRD, int'(rrd_q)));
      mrd_q <= MRD_W'(tick(cmd == C_LMR, T_MRD, int'(mrd_q)));
      rfc_q <= RFC_W'(tick(cmd == C_REF, T_RFC, int'(rfc_q)));
    end
  end
endmodule

// File: rtl/ddr_mon_select.sv
module ddr_mon_select
  import ddr_mon_pkg::*;
#(
  parameter int unsigned BA_W = 2,
  localparam int unsigned NBANK = 1 << BA_W
) (
  input  logic [NBANK-1:0][3:0] bank_codes,
  input  viol_e                 shared_code,
  input  logic [BA_W-1:0]       shared_bank,
  output viol_e                 code_o,
  output logic [BA_W-1:0]       bank_o
);
  viol_e           best;
  logic [BA_W-1:0] best_bank;

  always_comb begin
    best      = V_NONE;
    best_bank = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (viol_e'(bank_codes[i]) != V_NONE &&
          (best == V_NONE || viol_e'(bank_codes[i]) < best)) begin
        best      = viol_e'(bank_codes[i]);
        best_bank = BA_W'(i);
      end
    end
    code_o = pick_first(best, shared_code);
    if (code_o == V_NONE)             bank_o = '0;
    else if (code_o == shared_code)   bank_o = shared_bank;
    else                              bank_o = best_bank;
  end
endmodule

// File: rtl/ddr_cmd_timing_mon.sv
module ddr_cmd_timing_mon
  import ddr_mon_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned T_RCD  = 3,
  parameter int unsigned T_RAS  = 8,
  parameter int unsigned T_RC   = 11,
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_RRD  = 2,
  parameter int unsigned T_WR   = 3,
  parameter int unsigned T_MRD  = 2,
  parameter int unsigned T_RFC  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              viol_valid,
  output logic [3:0]        viol_code,
  output logic [BA_W-1:0]   viol_bank
);
  localparam int unsigned NBANK  = 1 << BA_W;
  localparam int unsigned AP_BIT = 10;

  // Named internal events, also observed by the bound checker.
  cmd_e                   cmd_w;
  logic [NBANK-1:0]       bank_open_w;
  logic [NBANK-1:0][3:0]  bank_code_w;
  viol_e                  shared_code_w;
  logic [BA_W-1:0]        shared_bank_w;
  viol_e                  sel_code_w;
  logic [BA_W-1:0]        sel_bank_w;
  logic                   pre_all_w;
  logic                   unused_addr_bits;

  assign pre_all_w        = addr[AP_BIT];
  assign unused_addr_bits = ^{addr[ADDR_W-1:AP_BIT+1], addr[AP_BIT-1:0]};

  ddr_mon_decode u_decode (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd_w)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    viol_e code_b;
    ddr_mon_bank #(
      .T_RCD (T_RCD),
      .T_RAS (T_RAS),
      .T_RC  (T_RC),
      .T_RP  (T_RP),
      .T_WR  (T_WR)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd_w),
      .hit     (ba == BA_W'(b)),
      .pre_all (pre_all_w),
      .open_o  (bank_open_w[b]),
      .code_o  (code_b)
    );
    assign bank_code_w[b] = code_b;
  end

  ddr_mon_shared #(
    .BA_W  (BA_W),
    .T_RRD (T_RRD),
    .T_MRD (T_MRD),
    .T_RFC (T_RFC)
  ) u_shared (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd_w),
    .ba        (ba),
    .bank_open (bank_open_w),
    .code_o    (shared_code_w),
    .bank_o    (shared_bank_w)
  );

  ddr_mon_select #(.BA_W(BA_W)) u_select (
    .bank_codes  (bank_code_w),
    .shared_code (shared_code_w),
    .shared_bank (shared_bank_w),
    .code_o      (sel_code_w),
    .bank_o      (sel_bank_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_code  <= 4'd0;
      viol_bank  <= '0;
    end else begin
      viol_valid <= (sel_code_w != V_NONE);
      viol_code  <= sel_code_w;
      viol_bank  <= sel_bank_w;
    end
  end
endmodule

// File: rtl/ddr_cmd_timing_mon_sva.sv
module ddr_cmd_timing_mon_sva
  import ddr_mon_pkg::*;
#(
  parameter int unsigned BA_W = 2,
  localparam int unsigned NBANK = 1 << BA_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic [BA_W-1:0]  ba,
  input logic             ap,
  input cmd_e             cmd,
  input logic [NBANK-1:0] bank_open,
  input logic             viol_valid,
  input logic [3:0]       viol_code,
  input logic [BA_W-1:0]  viol_bank
);
  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !viol_valid);

  assert_pulse_has_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> viol_code != 4'd0);

  assert_idle_is_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_valid |-> (viol_code == 4'd0 && viol_bank == '0));

  assert_closed_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == C_RD || cmd == C_WR) && !bank_open[ba])
      |=> (viol_valid && viol_code == 4'd1 && viol_bank == $past(ba)));

  assert_reopen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT && bank_open[ba]) |=> (viol_valid && viol_code == 4'd2));

  assert_refresh_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF && |bank_open) |=> (viol_valid && viol_code == 4'd3));

  assert_pre_all_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE && ap) |=> bank_open == '0);

  assert_act_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |=> bank_open[$past(ba)]);
endmodule

bind ddr_cmd_timing_mon ddr_cmd_timing_mon_sva #(.BA_W(BA_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .ba         (ba),
  .ap         (addr[AP_BIT]),
  .cmd        (cmd_w),
  .bank_open  (bank_open_w),
  .viol_valid (viol_valid),
  .viol_code  (viol_code),
  .viol_bank  (viol_bank)
);

// File: tb/sim_ddr_cmd_timing_mon.sv
`timescale 1ns/1ps
module sim_ddr_cmd_timing_mon;
  localparam int L_RCD = 3, L_RAS = 8, L_RC = 11, L_RP = 3;
  localparam int L_RRD = 2, L_WR = 3, L_MRD = 2, L_RFC = 14;

  // Bench-side operation names; encodings follow R1.
  localparam int OP_NOP = 0, OP_DES = 1, OP_ACT = 2, OP_RD = 3, OP_WR = 4;
  localparam int OP_PRE = 5, OP_PALL = 6, OP_REF = 7, OP_LMR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = 2'd0;
  logic [12:0] addr = 13'd0;
  logic        viol_valid;
  logic [3:0]  viol_code;
  logic [1:0]  viol_bank;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic       got_v;
  logic [3:0] got_c;
  logic [1:0] got_b;

  always #10 clk = ~clk;

  ddr_cmd_timing_mon #(
    .T_RCD(L_RCD), .T_RAS(L_RAS), .T_RC(L_RC), .T_RP(L_RP),
    .T_RRD(L_RRD), .T_WR(L_WR), .T_MRD(L_MRD), .T_RFC(L_RFC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .viol_valid(viol_valid), .viol_code(viol_code), .viol_bank(viol_bank)
  );

  function automatic int gap_code(int gap, int lim, int code);
    return (gap < lim) ? code : 0;
  endfunction

  // Drive one command for one cycle; returns with the response to it sampled.
  task automatic drive(input int op, input int b);
    cs_n = 1'b0;
    ba   = 2'(b);
    addr = 13'd0;
    case (op)
      OP_DES:  begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b101; end
      OP_ACT:  {ras_n, cas_n, we_n} = 3'b011;
      OP_RD:   {ras_n, cas_n, we_n} = 3'b101;
      OP_WR:   {ras_n, cas_n, we_n} = 3'b100;
      OP_PRE:  {ras_n, cas_n, we_n} = 3'b010;
      OP_PALL: begin {ras_n, cas_n, we_n} = 3'b010; addr[10] = 1'b1; end
      OP_REF:  {ras_n, cas_n, we_n} = 3'b001;
      OP_LMR:  {ras_n, cas_n, we_n} = 3'b000;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    @(negedge clk);
    got_v = viol_valid;
    got_c = viol_code;
    got_b = viol_bank;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) drive(OP_NOP, 0);
  endtask

  task automatic reset_dut;
    rst_n = 1'b0;
    cke   = 1'b1;
    cs_n  = 1'b1;
    @(negedge clk);
    @(negedge clk);
    got_v = viol_valid;
    got_c = viol_code;
    got_b = viol_bank;
    rst_n = 1'b1;
    drive(OP_DES, 0);
  endtask

  task automatic check(input string req, input int exp_code, input int exp_bank);
    logic       ev;
    logic [1:0] eb;
    ev = (exp_code != 0);
    eb = (exp_code == 0) ? 2'd0 : 2'(exp_bank);
    checks++;
    if (got_v !== ev || got_c !== 4'(exp_code) || got_b !== eb) begin
      failures++;
      $display("FAIL %s: got valid=%0b code=%0d bank=%0d, expected valid=%0b code=%0d bank=%0d",
               req, got_v, got_c, got_b, ev, exp_code, eb);
    end
  endtask

  initial begin
    #3000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    reset_dut;
    check("R2 reset state", 0, 0);

    // R1: deselect, NOP, CKE gating
    drive(OP_DES, 0);  check("R1 deselect ignored", 0, 0);
    drive(OP_NOP, 0);  check("R1 nop ignored", 0, 0);
    cke = 1'b0; drive(OP_NOP, 0);
    cke = 1'b1; drive(OP_RD, 0);  check("R1 cke low previous edge", 0, 0);
    drive(OP_RD, 0);              check("R1 sampled again R3", 1, 0);
    drive(OP_NOP, 0);             check("R2 single pulse", 0, 0);

    // R3: access to idle banks
    for (int b = 0; b < 4; b++) begin
      drive(OP_RD, b); check("R3 read closed", 1, b);
      drive(OP_WR, b); check("R3 write closed", 1, b);
    end
    drive(OP_PALL, 0); check("R3 closed write left no recovery", 0, 0);

    // R4
    reset_dut;
    drive(OP_ACT, 2); nops(11);
    drive(OP_ACT, 2); check("R4 activate open bank", 2, 2);

    // R5
    reset_dut;
    drive(OP_ACT, 3); nops(1); drive(OP_ACT, 1); nops(3);
    drive(OP_REF, 0); check("R5 refresh with open banks", 3, 1);

    // R6
    reset_dut;
    drive(OP_ACT, 0); nops(1); drive(OP_ACT, 1); nops(9);
    drive(OP_PRE, 0);  check("R6 single precharge", 0, 0);
    drive(OP_RD, 1);   check("R6 other bank still open", 0, 0);
    drive(OP_RD, 0);   check("R6 addressed bank closed", 1, 0);
    drive(OP_PALL, 2); check("R6 all-bank precharge", 0, 0);
    drive(OP_RD, 1);   check("R6 all banks closed", 1, 1);

    // R7
    for (int g = 1; g <= 4; g++) begin
      reset_dut; drive(OP_ACT, 1); nops(g - 1);
      drive(OP_RD, 1); check("R7 read after activate", gap_code(g, L_RCD, 4), 1);
      reset_dut; drive(OP_ACT, 1); nops(g - 1);
      drive(OP_WR, 1); check("R7 write after activate", gap_code(g, L_RCD, 4), 1);
    end

    // R8
    for (int g = 1; g <= 9; g++) begin
      reset_dut; drive(OP_ACT, 0); nops(g - 1);
      drive(OP_PRE, 0); check("R8 precharge after activate", gap_code(g, L_RAS, 5), 0);
    end
    for (int g = 1; g <= 4; g++) begin
      reset_dut; drive(OP_ACT, 0); nops(9); drive(OP_WR, 0); nops(g - 1);
      drive(OP_PRE, 0); check("R8 precharge after write", gap_code(g, L_WR, 6), 0);
    end

    // R9: precharge recovery alone
    for (int d = 1; d <= 4; d++) begin
      reset_dut; drive(OP_ACT, 2); nops(11); drive(OP_PRE, 2); nops(d - 1);
      drive(OP_ACT, 2); check("R9 activate after precharge", gap_code(d, L_RP, 8), 2);
    end
    // R9 with R12: row cycle and recovery broken together
    for (int d = 1; d <= 4; d++) begin
      reset_dut; drive(OP_ACT, 2); nops(L_RAS - 1); drive(OP_PRE, 2); nops(d - 1);
      drive(OP_ACT, 2);
      check("R9 R12 row cycle over recovery", gap_code(L_RAS + d, L_RC, 7), 2);
    end

    // R10
    for (int g = 1; g <= 3; g++) begin
      reset_dut; drive(OP_ACT, 0); nops(g - 1);
      drive(OP_ACT, 3); check("R10 activate to activate", gap_code(g, L_RRD, 9), 3);
    end

    // R11
    for (int g = 1; g <= 3; g++) begin
      reset_dut; drive(OP_LMR, g % 2); nops(g - 1);
      drive(OP_ACT, 1); check("R11 activate after load mode", gap_code(g, L_MRD, 10), 1);
      reset_dut; drive(OP_LMR, 1); nops(g - 1);
      drive(OP_REF, 0); check("R11 refresh after load mode", gap_code(g, L_MRD, 10), 0);
    end
    for (int k = 0; k < 4; k++) begin
      int g;
      g = (k == 0) ? 1 : (L_RFC - 2 + k);
      reset_dut; drive(OP_REF, 0); nops(g - 1);
      drive(OP_LMR, 1); check("R11 load mode after refresh", gap_code(g, L_RFC, 11), 1);
      reset_dut; drive(OP_REF, 0); nops(g - 1);
      drive(OP_PALL, 2); check("R11 precharge after refresh", gap_code(g, L_RFC, 11), 2);
    end

    // R12: lowest bank among several, and per-bank rule over shared rule
    reset_dut;
    drive(OP_ACT, 1); nops(1); drive(OP_ACT, 3);
    drive(OP_PALL, 0); check("R12 lowest violating bank", 5, 1);
    reset_dut;
    drive(OP_ACT, 0);
    drive(OP_ACT, 0); check("R12 reopen beats spacing rules", 2, 0);
    drive(OP_NOP, 0); check("R2 pulse drops", 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule